// File: doc/BRIEF.md
# Element-Serial Vector Register File and Lane

This block is a vector execution unit that sits beside a scalar controller. It stores a two-dimensional register array of 32 vector registers, each with 32 elements of 64 bits. It runs one vector command at a time. A command names a destination register, up to two source registers and, where needed, a scalar value. The unit then steps through the elements at one element per clock, up to the current vector length. Element-wise arithmetic comes in two forms. The vector-vector form pairs element i of two sources. The scalar-vector form applies one scalar to every element of a single source.

Unit-stride vector loads and stores use a simple word-addressed memory port. The scalar value of the command supplies the base address. Memory allows one access per cycle, and read data returns one cycle after the request. The controller sets the active element count through a vector-length register. It starts a command when `busy` is low and learns that the command has completed from a one-cycle `done` pulse. A combinational read port lets a checker inspect any element at any time.

Top module: `vec_unit`

## Requirements
- R1: After reset, every element of every register reads 0, `busy` and `done` are low, and the vector length is 32.
- R2: Opcode 0 writes vs1[i] + vs2[i] (modulo 2^64) into vd[i], and opcode 1 writes the low 64 bits of vs1[i] * vs2[i] into vd[i], for every i below the vector length.
- R3: Opcode 2 writes scalar + vs1[i] (modulo 2^64) into vd[i], and opcode 3 writes the low 64 bits of scalar * vs1[i] into vd[i], for every i below the vector length.
- R4: Elements of the destination at or above the vector length keep their previous value, and so do memory words at or beyond base + vector length.
- R5: Writing 0 to the vector length sets it to 1, and writing a value above 32 sets it to 32. A command uses the length that was in force when it was accepted, even if the length is rewritten while the command runs.
- R6: An arithmetic command accepted at clock edge E0 holds `busy` high until edge E0+VL. `done` is high for exactly the one cycle after that edge.
- R7: Opcode 4 (load) reads the words at base + i, using the scalar's low address bits, into vd[i]. With the one-cycle read latency it holds `busy` for VL+1 cycles, and `done` follows as in R6.
- R8: Opcode 5 (store) writes vs1[i] to address base + i, one word per cycle. It holds `busy` for VL cycles, and `done` follows as in R6.
- R9: A command presented while `busy` is high is ignored, and so is a command with opcode 6 or 7. Neither changes any register, memory word or `busy`.
- R10: A destination that is also a source is updated in place, and each element is computed from that element's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 3 | Opcode: 0 add.vv, 1 mul.vv, 2 add.sv, 3 mul.sv, 4 load, 5 store |
| cmd_vd | input | 5 | Destination vector register |
| cmd_vs1 | input | 5 | First source (store data source) |
| cmd_vs2 | input | 5 | Second source (vector-vector forms only) |
| cmd_scalar | input | 64 | Scalar operand or memory base address |
| vl_wr | input | 1 | Write strobe for the vector length |
| vl_in | input | 8 | New vector length before clamping |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse after a command finishes |
| rd_reg | input | 5 | Inspection port register select |
| rd_elem | input | 5 | Inspection port element select |
| rd_data | output | 64 | Inspected element value |
| mem_addr | output | 16 | Word address to memory |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid one cycle after mem_re |

## Verification
The bench checks that loads deliver every element despite the one-cycle read latency. If the writeback were not delayed, each element would receive its neighbour's word and the last element would be lost. It drives vector lengths of 0, 1, 5, 7, 32 and 40 to expose off-by-one errors in the element count. It also rewrites the length during a running command, where a unit that fails to latch the length would stop early. Further runs check in-place updates, wrap-around in add and multiply, stores whose final word falls just before an untouched address, and commands that arrive while the unit is busy or carry illegal opcodes. In each of those cases a flawed unit would overwrite data it should leave alone.

// File: rtl/vec_pkg.sv
// Shared opcode definitions for the vector unit.
// Assumes a 3-bit opcode field; codes 6 and 7 are not legal.
package vec_pkg;

    typedef enum logic [2:0] {
        OP_ADD_VV = 3'd0,
        OP_MUL_VV = 3'd1,
        OP_ADD_SV = 3'd2,
        OP_MUL_SV = 3'd3,
        OP_LOAD   = 3'd4,
        OP_STORE  = 3'd5
    } vop_e;

    function automatic logic op_legal(input logic [2:0] op);
        return op <= 3'd5;
    endfunction

endpackage

// File: rtl/vec_regfile.sv
// Vector register storage: NREG registers of MAXVL elements each.
// One synchronous write port, three combinational read ports.
// Assumes NREG and MAXVL are powers of two, so an element is addressed
// by concatenating register and element index.
module vec_regfile #(
    parameter int DW    = 64,
    parameter int NREG  = 32,
    parameter int MAXVL = 32,
    localparam int RW    = $clog2(NREG),
    localparam int EW    = $clog2(MAXVL),
    localparam int DEPTH = NREG * MAXVL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_reg,
    input  logic [EW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [RW-1:0] a_reg,
    input  logic [EW-1:0] a_idx,
    output logic [DW-1:0] a_data,
    input  logic [RW-1:0] b_reg,
    input  logic [EW-1:0] b_idx,
    output logic [DW-1:0] b_data,
    input  logic [RW-1:0] c_reg,
    input  logic [EW-1:0] c_idx,
    output logic [DW-1:0] c_data
);

    logic [DW-1:0] store_q [DEPTH];

    // Clear on reset, otherwise write one element per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) store_q[k] <= '0;
        end else if (wr_en) begin
            store_q[{wr_reg, wr_idx}] <= wr_data;
        end
    end

    // Read ports see the value before any write in the same cycle.
    always_comb begin
        a_data = store_q[{a_reg, a_idx}];
        b_data = store_q[{b_reg, b_idx}];
        c_data = store_q[{c_reg, c_idx}];
    end

endmodule

// File: rtl/vec_alu.sv
// Element arithmetic: wrapping add or low half of a product.
// Purely combinational; the result width equals the operand width.
module vec_alu #(
    parameter int DW = 64
) (
    input  logic          is_mul,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    // Select the operation; truncation to DW bits gives the wrap.
    always_comb begin
        if (is_mul) y = a * b;
        else        y = a + b;
    end

endmodule

// File: rtl/vec_seq.sv
// Command sequencer: accepts one command when idle, latches its fields
// and the vector length, and steps an element index once per cycle.
// Loads add one writeback stage for the one-cycle memory read latency.
// Assumes vl is already clamped to 1..MAXVL.
module vec_seq
    import vec_pkg::*;
#(
    parameter int DW    = 64,
    parameter int NREG  = 32,
    parameter int MAXVL = 32,
    parameter int AW    = 16,
    localparam int RW = $clog2(NREG),
    localparam int EW = $clog2(MAXVL),
    localparam int LW = EW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [RW-1:0] cmd_vd,
    input  logic [RW-1:0] cmd_vs1,
    input  logic [RW-1:0] cmd_vs2,
    input  logic [DW-1:0] cmd_scalar,
    input  logic [LW-1:0] vl,
    output logic          busy,
    output logic          done,
    output logic [RW-1:0] src1_reg,
    output logic [RW-1:0] src2_reg,
    output logic [EW-1:0] rd_idx,
    output logic          wr_en,
    output logic [RW-1:0] wr_reg,
    output logic [EW-1:0] wr_idx,
    output logic          wr_from_mem,
    output logic          alu_mul,
    output logic          use_scalar,
    output logic [DW-1:0] scalar,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we
);

    logic          busy_q, done_q, issuing_q, wb_v_q;
    vop_e          op_q;
    logic [RW-1:0] vd_q, vs1_q, vs2_q;
    logic [DW-1:0] scal_q;
    logic [LW-1:0] vl_q, iss_q;
    logic [EW-1:0] wb_idx_q;

    logic accept, is_load, is_store, is_arith, last_iss, last_wb;

    // Decode the latched command and the end-of-vector conditions.
    always_comb begin
        accept   = cmd_valid && !busy_q && op_legal(cmd_op);
        is_load  = (op_q == OP_LOAD);
        is_store = (op_q == OP_STORE);
        is_arith = !is_load && !is_store;
        last_iss = (iss_q == vl_q - LW'(1));
        last_wb  = ({1'b0, wb_idx_q} == vl_q - LW'(1));
    end

    // Command acceptance, element stepping and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            issuing_q <= 1'b0;
            wb_v_q    <= 1'b0;
            wb_idx_q  <= '0;
            op_q      <= OP_ADD_VV;
            vd_q      <= '0;
            vs1_q     <= '0;
            vs2_q     <= '0;
            scal_q    <= '0;
            vl_q      <= LW'(MAXVL);
            iss_q     <= '0;
        end else begin
            done_q   <= 1'b0;
            wb_v_q   <= busy_q && issuing_q && is_load;
            wb_idx_q <= iss_q[EW-1:0];
            if (accept) begin
                busy_q    <= 1'b1;
                issuing_q <= 1'b1;
                iss_q     <= '0;
                op_q      <= vop_e'(cmd_op);
                vd_q      <= cmd_vd;
                vs1_q     <= cmd_vs1;
                vs2_q     <= cmd_vs2;
                scal_q    <= cmd_scalar;
                vl_q      <= vl;
            end else if (busy_q) begin
                if (issuing_q) begin
                    iss_q <= iss_q + LW'(1);
                    if (last_iss) begin
                        issuing_q <= 1'b0;
                        if (!is_load) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end
                if (is_load && wb_v_q && last_wb) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Drive datapath and memory controls from the latched command.
    always_comb begin
        busy        = busy_q;
        done        = done_q;
        src1_reg    = vs1_q;
        src2_reg    = vs2_q;
        rd_idx      = iss_q[EW-1:0];
        wr_reg      = vd_q;
        wr_from_mem = is_load;
        wr_en       = busy_q && (is_load ? wb_v_q : (issuing_q && is_arith));
        wr_idx      = is_load ? wb_idx_q : iss_q[EW-1:0];
        alu_mul     = (op_q == OP_MUL_VV) || (op_q == OP_MUL_SV);
        use_scalar  = (op_q == OP_ADD_SV) || (op_q == OP_MUL_SV);
        scalar      = scal_q;
        mem_addr    = scal_q[AW-1:0] + AW'(iss_q);
        mem_re      = busy_q && issuing_q && is_load;
        mem_we      = busy_q && issuing_q && is_store;
    end

endmodule

// File: rtl/vec_unit.sv
// Vector unit top: holds the clamped vector-length register and joins
// the sequencer, register file and element ALU. One element per cycle.
// Assumes memory answers a read one cycle after mem_re.
module vec_unit #(
    parameter int DW    = 64,
    parameter int NREG  = 32,
    parameter int MAXVL = 32,
    parameter int AW    = 16,
    parameter int VLW   = 8,
    localparam int RW = $clog2(NREG),
    localparam int EW = $clog2(MAXVL),
    localparam int LW = EW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [RW-1:0]  cmd_vd,
    input  logic [RW-1:0]  cmd_vs1,
    input  logic [RW-1:0]  cmd_vs2,
    input  logic [DW-1:0]  cmd_scalar,
    input  logic           vl_wr,
    input  logic [VLW-1:0] vl_in,
    output logic           busy,
    output logic           done,
    input  logic [RW-1:0]  rd_reg,
    input  logic [EW-1:0]  rd_elem,
    output logic [DW-1:0]  rd_data,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_re,
    output logic           mem_we,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata
);

    logic [LW-1:0] vl_q;
    logic [RW-1:0] src1_reg, src2_reg, wr_reg;
    logic [EW-1:0] rd_idx, wr_idx;
    logic          wr_en, wr_from_mem, alu_mul, use_scalar;
    logic [DW-1:0] scalar, a_data, b_data, alu_b, alu_y, wr_data;

    // Vector-length register, clamped into 1..MAXVL on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       vl_q <= LW'(MAXVL);
        else if (vl_wr) begin
            if (vl_in == '0)              vl_q <= LW'(1);
            else if (vl_in > VLW'(MAXVL)) vl_q <= LW'(MAXVL);
            else                          vl_q <= vl_in[LW-1:0];
        end
    end

    vec_seq #(.DW(DW), .NREG(NREG), .MAXVL(MAXVL), .AW(AW)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vd(cmd_vd),
        .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2), .cmd_scalar(cmd_scalar),
        .vl(vl_q), .busy(busy), .done(done),
        .src1_reg(src1_reg), .src2_reg(src2_reg), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx),
        .wr_from_mem(wr_from_mem), .alu_mul(alu_mul),
        .use_scalar(use_scalar), .scalar(scalar),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we)
    );

    vec_regfile #(.DW(DW), .NREG(NREG), .MAXVL(MAXVL)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
        .a_reg(src1_reg), .a_idx(rd_idx), .a_data(a_data),
        .b_reg(src2_reg), .b_idx(rd_idx), .b_data(b_data),
        .c_reg(rd_reg), .c_idx(rd_elem), .c_data(rd_data)
    );

    // Second ALU operand is either the scalar or the second vector source.
    always_comb alu_b = use_scalar ? scalar : b_data;

    vec_alu #(.DW(DW)) alu_i (
        .is_mul(alu_mul), .a(a_data), .b(alu_b), .y(alu_y)
    );

    // Writeback source and store data selection.
    always_comb begin
        wr_data   = wr_from_mem ? mem_rdata : alu_y;
        mem_wdata = a_data;
    end

endmodule

// File: rtl/vec_unit_chk.sv
// Protocol checker for vec_unit, attached by bind. Observes ports only.
module vec_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          busy,
    input logic          done,
    input logic          mem_re,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);

    // R6: done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only while idle, right after busy drops
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: no read and write in the same cycle
    assert_mem_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R7: consecutive reads step the address by one word
    assert_load_stride_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> mem_addr == $past(mem_addr) + AW'(1));

    // R8: consecutive writes step the address by one word
    assert_store_stride_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + AW'(1));

    // R9: memory is untouched while idle
    assert_mem_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !mem_we));

    // R9: legal command while idle starts work, illegal one does not
    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op <= 3'd5) |=> busy);

    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op > 3'd5) |=> !busy);

endmodule

bind vec_unit vec_unit_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr)
);

// File: tb/vec_unit_tb_top.sv
// Self-checking bench: behavioural reference model updated on each clock,
// busy/done compared every cycle, register and memory contents compared
// through the ports after each command.
module vec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [4:0]  cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
    logic [63:0] cmd_scalar = '0;
    logic        vl_wr = 1'b0;
    logic [7:0]  vl_in = '0;
    logic        busy, done;
    logic [4:0]  rd_reg = '0, rd_elem = '0;
    logic [63:0] rd_data;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    always #5 clk = ~clk;

    vec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2),
        .cmd_scalar(cmd_scalar), .vl_wr(vl_wr), .vl_in(vl_in),
        .busy(busy), .done(done), .rd_reg(rd_reg), .rd_elem(rd_elem),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory seen by the design, and the expected memory of the model.
    logic [63:0] bmem    [1024];
    logic [63:0] exp_mem [1024];

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= bmem[mem_addr[9:0]];
    end

    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state.
    logic [63:0] mrf [32][32];
    bit          m_busy, m_done;
    int          m_vl, m_left;
    string       m_tag = "R1";

    function automatic int clampv(int v);
        if (v == 0) return 1;
        if (v > 32) return 32;
        return v;
    endfunction

    function automatic logic [63:0] pat(int a);
        return (64'(a) * 64'h9E37_79B9_7F4A_7C15) ^ 64'hF00D_0000_0000_0003;
    endfunction

    // Model: whole command applied at acceptance, timing tracked by count.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_vl = 32; m_left = 0;
            for (int r = 0; r < 32; r++)
                for (int e = 0; e < 32; e++) mrf[r][e] = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_done = 1; end
            end else if (cmd_valid && cmd_op <= 3'd5) begin
                for (int i = 0; i < m_vl; i++) begin
                    case (cmd_op)
                        3'd0: mrf[cmd_vd][i] = mrf[cmd_vs1][i] + mrf[cmd_vs2][i];
                        3'd1: mrf[cmd_vd][i] = mrf[cmd_vs1][i] * mrf[cmd_vs2][i];
                        3'd2: mrf[cmd_vd][i] = cmd_scalar + mrf[cmd_vs1][i];
                        3'd3: mrf[cmd_vd][i] = cmd_scalar * mrf[cmd_vs1][i];
                        3'd4: mrf[cmd_vd][i] = exp_mem[(int'(cmd_scalar[15:0]) + i) % 1024];
                        default: exp_mem[(int'(cmd_scalar[15:0]) + i) % 1024] = mrf[cmd_vs1][i];
                    endcase
                end
                m_busy = 1;
                m_left = (cmd_op == 3'd4) ? m_vl + 1 : m_vl;
                m_tag  = (cmd_op == 3'd4) ? "R7" : (cmd_op == 3'd5) ? "R8" : "R6";
            end
            if (vl_wr) m_vl = clampv(int'(vl_in));
        end
    end

    // Per-cycle comparison of the handshake, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk({m_tag, " busy"}, 64'(busy), 64'(m_busy));
            chk({m_tag, " done"}, 64'(done), 64'(m_done));
        end
    end

    task automatic print_summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
            print_summary();
            $finish;
        end
    end

    task automatic set_vl(int v);
        @(negedge clk);
        vl_wr = 1'b1; vl_in = 8'(v);
        @(negedge clk);
        vl_wr = 1'b0;
    endtask

    task automatic issue(int op, int vd, int vs1, int vs2, logic [63:0] sc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op);
        cmd_vd = 5'(vd); cmd_vs1 = 5'(vs1); cmd_vs2 = 5'(vs2); cmd_scalar = sc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_reg(int r, string tag);
        for (int e = 0; e < 32; e++) begin
            rd_reg = 5'(r); rd_elem = 5'(e);
            #1;
            chk($sformatf("%s v%0d[%0d]", tag, r, e), rd_data, mrf[r][e]);
        end
    endtask

    task automatic check_mem(int lo, int hi, string tag);
        for (int a = lo; a <= hi; a++)
            chk($sformatf("%s mem[%0d]", tag, a), bmem[a], exp_mem[a]);
    endtask

    initial begin
        for (int a = 0; a < 1024; a++) begin
            bmem[a] = pat(a); exp_mem[a] = pat(a);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_reg(0, "R1");
        check_reg(31, "R1");

        // R7: full-length loads
        issue(4, 1, 0, 0, 64'd0);   wait_idle(); check_reg(1, "R7");
        issue(4, 2, 0, 0, 64'd100); wait_idle(); check_reg(2, "R7");

        // R2: vector-vector add and multiply
        issue(0, 3, 1, 2, 64'd0); wait_idle(); check_reg(3, "R2");
        issue(1, 4, 1, 2, 64'd0); wait_idle(); check_reg(4, "R2");

        // R3 / R4: scalar add with wrap, short length
        set_vl(5);
        issue(2, 5, 1, 0, '1); wait_idle(); check_reg(5, "R3 R4");

        // R10 / R3: in-place scalar multiply, tail kept
        issue(3, 4, 4, 0, 64'd3); wait_idle(); check_reg(4, "R10 R4");

        // R5: length 0 clamps to 1
        set_vl(0);
        issue(0, 6, 1, 1, 64'd0); wait_idle(); check_reg(6, "R5");

        // R5: length 40 clamps to 32
        set_vl(40);
        issue(0, 7, 3, 1, 64'd0); wait_idle(); check_reg(7, "R5");

        // R8: store of 7 words, following word untouched
        set_vl(7);
        issue(5, 0, 3, 0, 64'd500); wait_idle(); check_mem(498, 508, "R8 R4");

        // R7: short load leaves tail zero
        set_vl(4);
        issue(4, 8, 0, 0, 64'd200); wait_idle(); check_reg(8, "R7 R4");

        // R9: command during busy is ignored
        set_vl(32);
        issue(0, 9, 1, 2, 64'd0);
        issue(0, 10, 1, 1, 64'd0);
        wait_idle(); check_reg(9, "R9"); check_reg(10, "R9");

        // R9: illegal opcodes are ignored
        issue(6, 11, 1, 2, 64'd0);
        issue(7, 11, 1, 2, 64'd0);
        repeat (2) @(negedge clk);
        check_reg(11, "R9");

        // R5: length rewritten while running does not cut the command short
        issue(1, 12, 1, 2, 64'd0);
        set_vl(3);
        wait_idle(); check_reg(12, "R5");
        issue(0, 13, 1, 2, 64'd0); wait_idle(); check_reg(13, "R5");

        // R10: vector-vector in place
        issue(0, 2, 2, 1, 64'd0); wait_idle(); check_reg(2, "R10");

        finished = 1;
        print_summary();
        $finish;
    end

endmodule